// File: doc/BRIEF.md
# Multi-port GPIO register controller

This block is a memory-mapped general purpose I/O controller. It has three ordinary ports and one mixed port, and a host reaches all of them through a simple 32-bit register bus. Output levels, pin directions and one stored mux word are changed only through paired set and clear registers. A write to a set register drives the selected bits high, a write to a clear register drives them low, and zero bits in the write data have no effect. Read-only state registers return output levels, directions and synchronised pad inputs.

Port 3 is a mixed port. It has six bidirectional pins, input-only pins and 24 output-only pins, and these share register words at scattered bit positions. The bidirectional pins get their direction control from spare bits of the port 2 direction register. Each pin is modelled as separate input, output and output-enable vectors. Pad drivers, pin muxing beyond storing the mux word, and interrupts are outside the block.

Top module: `gpio_mport_ctrl`

## Requirements
- R1: After reset all output levels, direction bits, output enables and the mux word are 0, so every bidirectional pin starts as an input.
- R2: A write to a set register drives every bit that is 1 in the write data high and leaves the bits that are 0 unchanged.
- R3: A write to a clear register drives every bit that is 1 in the write data low and leaves the bits that are 0 unchanged.
- R4: On ports 0, 1 and 2 a direction bit of 1 turns on the pin's output enable and 0 makes the pin an input. Bits above a port's width are ignored and read back as 0.
- R5: Byte offsets. Port 3: input state 0x00, output set 0x04, output clear 0x08, output state 0x0C. Port 2: direction set 0x10, clear 0x14, state 0x18; input state 0x1C; output set 0x20, clear 0x24; mux set 0x28, clear 0x2C, state 0x30. Port 0 starts at 0x40 and port 1 at 0x60, each with input state +0x00, output set +0x04, clear +0x08, state +0x0C, direction set +0x10, clear +0x14, state +0x18. Read data is registered and appears on rdata_o in the cycle after the read request.
- R6: Bidirectional pin n of port 3 uses bit n+25 of the port 3 output set/clear/state words for its level and bit n+25 of the port 2 direction set/clear/state words for its output enable.
- R7: In the port 3 input-state word, bidirectional pins 0..4 read at bits 10..14 and pin 5 reads at bit 24.
- R8: Input-only pin n of port 3 reads at input-state bit n for n in 0..9, 15..23 and 25..28. Input pins 10..14 and 24 are ignored, because those bits carry the bidirectional pins.
- R9: Output-only pin n of port 3 is driven by set/clear bit n (n in 0..23) and reads back at output-state bit n.
- R10: Every pad input passes through two flip-flops. A level applied before clock edge k is seen by a read captured at edge k+2, and not by a read captured at edge k+1.
- R11: Reads of set and clear offsets return 0. Reads of unmapped offsets return 0, and writes to unmapped offsets change no state.
- R12: p2_mux_o is the stored mux word. It is written through the mux set/clear pair and read at the mux state offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after a read request |
| p0_in_i | input | P0_W | Port 0 pad inputs |
| p0_out_o | output | P0_W | Port 0 output levels |
| p0_oe_o | output | P0_W | Port 0 output enables |
| p1_in_i | input | P1_W | Port 1 pad inputs |
| p1_out_o | output | P1_W | Port 1 output levels |
| p1_oe_o | output | P1_W | Port 1 output enables |
| p2_in_i | input | P2_W | Port 2 pad inputs |
| p2_out_o | output | P2_W | Port 2 output levels |
| p2_oe_o | output | P2_W | Port 2 output enables |
| p2_mux_o | output | MUX_W | Stored mux word |
| p3_io_in_i | input | 6 | Port 3 bidirectional pad inputs |
| p3_io_out_o | output | 6 | Port 3 bidirectional output levels |
| p3_io_oe_o | output | 6 | Port 3 bidirectional output enables |
| p3_gpi_i | input | 29 | Port 3 input-only pins |
| p3_gpo_o | output | 24 | Port 3 output-only pins |

## Verification
The bench uses the default parameters: port widths 8, 24 and 13, a 32-bit mux word, and two synchroniser stages. With these widths, writes with all bits set reach past each port's top bit, so the masking at every width boundary is exercised. The full 32-bit mux word tests the set/clear pair across all bit lanes. With exactly two stages, reading just before and just after the synchroniser delay tells a correct latency apart from one that is a cycle short or a cycle long.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFS_P3_INP  = 8'h00;
  localparam logic [AW-1:0] OFS_P3_OSET = 8'h04;
  localparam logic [AW-1:0] OFS_P3_OCLR = 8'h08;
  localparam logic [AW-1:0] OFS_P3_OST  = 8'h0C;
  localparam logic [AW-1:0] OFS_P2_DSET = 8'h10;
  localparam logic [AW-1:0] OFS_P2_DCLR = 8'h14;
  localparam logic [AW-1:0] OFS_P2_DST  = 8'h18;
  localparam logic [AW-1:0] OFS_P2_INP  = 8'h1C;
  localparam logic [AW-1:0] OFS_P2_OSET = 8'h20;
  localparam logic [AW-1:0] OFS_P2_OCLR = 8'h24;
  localparam logic [AW-1:0] OFS_P2_MSET = 8'h28;
  localparam logic [AW-1:0] OFS_P2_MCLR = 8'h2C;
  localparam logic [AW-1:0] OFS_P2_MST  = 8'h30;

  localparam logic [AW-1:0] P0_BASE = 8'h40;
  localparam logic [AW-1:0] P1_BASE = 8'h60;

  // offsets inside a standard port window
  localparam logic [AW-1:0] REL_INP  = 8'h00;
  localparam logic [AW-1:0] REL_OSET = 8'h04;
  localparam logic [AW-1:0] REL_OCLR = 8'h08;
  localparam logic [AW-1:0] REL_OST  = 8'h0C;
  localparam logic [AW-1:0] REL_DSET = 8'h10;
  localparam logic [AW-1:0] REL_DCLR = 8'h14;
  localparam logic [AW-1:0] REL_DST  = 8'h18;

  // mixed port layout
  localparam int unsigned P3_IO_W   = 6;
  localparam int unsigned P3_GPI_W  = 29;
  localparam int unsigned P3_GPO_W  = 24;
  localparam int unsigned P3_IO_LSB = 25;  // out/dir bit of bidir pin 0
  localparam int unsigned P3_RD_LSB = 10;  // input-state bit of bidir pin 0
  localparam int unsigned P3_RD_HI  = 24;  // input-state bit of bidir pin 5

  localparam logic [31:0] P3_IO_FIELD  = 32'h7E00_0000;
  localparam logic [31:0] P3_GPO_FIELD = 32'h00FF_FFFF;
  localparam logic [31:0] P3_GPI_FIELD = 32'h1EFF_83FF;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              warm_q <= '0;
      else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end
    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R10
  end
endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (set_i) q_q <= q_q | bits_i;
    else if (clr_i) q_q <= q_q & ~bits_i;
  end

  assign q_o = q_q;

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(bits_i)) == $past(bits_i))); // R2
  AST_SET_KEEPS_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & ~$past(bits_i)) == ($past(q_o) & ~$past(bits_i)))); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(bits_i)) == '0)); // R3
  AST_CLR_KEEPS_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & ~$past(bits_i)) == ($past(q_o) & ~$past(bits_i)))); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)); // R11
endmodule

// File: rtl/gpio_std_port.sv
module gpio_std_port
  import gpio_mport_pkg::*;
#(
  parameter int unsigned   W       = 8,
  parameter int unsigned   STAGES  = 2,
  parameter logic [AW-1:0] BASE    = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  out_o,
  output logic [W-1:0]  oe_o,
  output logic          hit_o,
  output logic [31:0]   rdata_o
);
  logic [AW-1:0] rel;
  logic          in_win, wr;
  logic [W-1:0]  pad_q;

  assign rel    = addr_i - BASE;
  assign in_win = (addr_i >= BASE) && (rel <= REL_DST) && (addr_i[1:0] == 2'b00);
  assign hit_o  = in_win;
  assign wr     = req_i && we_i && in_win;

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_q)
  );

  gpio_setclr #(.W(W)) u_out (
    .clk_i, .rst_ni,
    .set_i (wr && rel == REL_OSET),
    .clr_i (wr && rel == REL_OCLR),
    .bits_i(wdata_i),
    .q_o   (out_o)
  );

  gpio_setclr #(.W(W)) u_dir (
    .clk_i, .rst_ni,
    .set_i (wr && rel == REL_DSET),
    .clr_i (wr && rel == REL_DCLR),
    .bits_i(wdata_i),
    .q_o   (oe_o)
  );

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      case (rel)
        REL_INP: rdata_o = 32'(pad_q);
        REL_OST: rdata_o = 32'(out_o);
        REL_DST: rdata_o = 32'(oe_o);
        default: rdata_o = '0;
      endcase
    end
  end

  AST_DIR_CLR_TO_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && rel == REL_DCLR && wdata_i[0]) |=> !oe_o[0]); // R4
  AST_DIR_SET_TO_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && rel == REL_DSET && wdata_i[0]) |=> oe_o[0]); // R4
endmodule

// File: rtl/gpio_mport_ctrl.sv
module gpio_mport_ctrl
  import gpio_mport_pkg::*;
#(
  parameter int unsigned P0_W        = 8,
  parameter int unsigned P1_W        = 24,
  parameter int unsigned P2_W        = 13,
  parameter int unsigned MUX_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [P0_W-1:0]     p0_in_i,
  output logic [P0_W-1:0]     p0_out_o,
  output logic [P0_W-1:0]     p0_oe_o,
  input  logic [P1_W-1:0]     p1_in_i,
  output logic [P1_W-1:0]     p1_out_o,
  output logic [P1_W-1:0]     p1_oe_o,
  input  logic [P2_W-1:0]     p2_in_i,
  output logic [P2_W-1:0]     p2_out_o,
  output logic [P2_W-1:0]     p2_oe_o,
  output logic [MUX_W-1:0]    p2_mux_o,
  input  logic [P3_IO_W-1:0]  p3_io_in_i,
  output logic [P3_IO_W-1:0]  p3_io_out_o,
  output logic [P3_IO_W-1:0]  p3_io_oe_o,
  input  logic [P3_GPI_W-1:0] p3_gpi_i,
  output logic [P3_GPO_W-1:0] p3_gpo_o
);
  localparam logic [31:0] P2_MASK     = 32'((64'd1 << P2_W) - 64'd1);
  localparam logic [31:0] P2_DIR_MASK = P2_MASK | P3_IO_FIELD;
  localparam logic [31:0] P3_OUT_MASK = P3_GPO_FIELD | P3_IO_FIELD;

  logic        wr;
  logic        p0_hit, p1_hit, mapped;
  logic [31:0] p0_rd, p1_rd, rd_mux;
  logic [31:0] p2_dir, p3_out, p3_raw, p3_in_q;
  logic [P2_W-1:0] p2_in_q;

  assign wr = req_i && we_i;

  gpio_std_port #(.W(P0_W), .STAGES(SYNC_STAGES), .BASE(P0_BASE)) u_p0 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .wdata_i(wdata_i[P0_W-1:0]), .pad_i(p0_in_i),
    .out_o(p0_out_o), .oe_o(p0_oe_o), .hit_o(p0_hit), .rdata_o(p0_rd)
  );

  gpio_std_port #(.W(P1_W), .STAGES(SYNC_STAGES), .BASE(P1_BASE)) u_p1 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .wdata_i(wdata_i[P1_W-1:0]), .pad_i(p1_in_i),
    .out_o(p1_out_o), .oe_o(p1_oe_o), .hit_o(p1_hit), .rdata_o(p1_rd)
  );

  // port 2 levels, port 2 + port 3 bidir directions, mux word
  gpio_setclr #(.W(P2_W)) u_p2_out (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == OFS_P2_OSET),
    .clr_i (wr && addr_i == OFS_P2_OCLR),
    .bits_i(wdata_i[P2_W-1:0]),
    .q_o   (p2_out_o)
  );

  gpio_setclr #(.W(32)) u_p2_dir (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == OFS_P2_DSET),
    .clr_i (wr && addr_i == OFS_P2_DCLR),
    .bits_i(wdata_i & P2_DIR_MASK),
    .q_o   (p2_dir)
  );

  gpio_setclr #(.W(MUX_W)) u_p2_mux (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == OFS_P2_MSET),
    .clr_i (wr && addr_i == OFS_P2_MCLR),
    .bits_i(wdata_i[MUX_W-1:0]),
    .q_o   (p2_mux_o)
  );

  // port 3 output word: output-only pins low, bidir levels high
  gpio_setclr #(.W(32)) u_p3_out (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == OFS_P3_OSET),
    .clr_i (wr && addr_i == OFS_P3_OCLR),
    .bits_i(wdata_i & P3_OUT_MASK),
    .q_o   (p3_out)
  );

  assign p2_oe_o     = p2_dir[P2_W-1:0];
  assign p3_io_oe_o  = p2_dir[P3_IO_LSB +: P3_IO_W];
  assign p3_io_out_o = p3_out[P3_IO_LSB +: P3_IO_W];
  assign p3_gpo_o    = p3_out[P3_GPO_W-1:0];

  // scatter mixed-port inputs into one word before synchronising
  always_comb begin
    p3_raw = 32'(p3_gpi_i) & P3_GPI_FIELD;
    for (int n = 0; n < P3_IO_W - 1; n++) p3_raw[P3_RD_LSB + n] = p3_io_in_i[n];
    p3_raw[P3_RD_HI] = p3_io_in_i[P3_IO_W-1];
  end

  gpio_sync #(.W(P2_W), .STAGES(SYNC_STAGES)) u_p2_sync (
    .clk_i, .rst_ni, .d_i(p2_in_i), .q_o(p2_in_q)
  );

  gpio_sync #(.W(32), .STAGES(SYNC_STAGES)) u_p3_sync (
    .clk_i, .rst_ni, .d_i(p3_raw), .q_o(p3_in_q)
  );

  always_comb begin
    rd_mux = p0_rd | p1_rd;
    mapped = p0_hit | p1_hit;
    case (addr_i)
      OFS_P3_INP: begin rd_mux = p3_in_q;           mapped = 1'b1; end
      OFS_P3_OST: begin rd_mux = p3_out;            mapped = 1'b1; end
      OFS_P2_DST: begin rd_mux = p2_dir;            mapped = 1'b1; end
      OFS_P2_INP: begin rd_mux = 32'(p2_in_q);      mapped = 1'b1; end
      OFS_P2_MST: begin rd_mux = 32'(p2_mux_o);     mapped = 1'b1; end
      OFS_P3_OSET, OFS_P3_OCLR, OFS_P2_DSET, OFS_P2_DCLR,
      OFS_P2_OSET, OFS_P2_OCLR, OFS_P2_MSET, OFS_P2_MCLR:
        mapped = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_mux;
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> (rdata_o == '0)); // R11
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R5
  AST_P3_OE_FROM_P2_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_P2_DSET && wdata_i[P3_IO_LSB]) |=> p3_io_oe_o[0]); // R6
  AST_P3_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_P3_OSET && wdata_i[P3_IO_LSB + P3_IO_W - 1]) |=> p3_io_out_o[P3_IO_W-1]); // R6
  AST_P3_GPO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_P3_OCLR && wdata_i[0]) |=> !p3_gpo_o[0]); // R9
endmodule

// File: tb/gpio_mport_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_mport_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  p0_in = '0, p0_out, p0_oe;
  logic [23:0] p1_in = '0, p1_out, p1_oe;
  logic [12:0] p2_in = '0, p2_out, p2_oe;
  logic [31:0] p2_mux;
  logic [5:0]  p3_io_in = '0, p3_io_out, p3_io_oe;
  logic [28:0] p3_gpi = '0;
  logic [23:0] p3_gpo;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #2 clk = ~clk;

  gpio_mport_ctrl u_gpio_mport_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .p0_in_i(p0_in), .p0_out_o(p0_out), .p0_oe_o(p0_oe),
    .p1_in_i(p1_in), .p1_out_o(p1_out), .p1_oe_o(p1_oe),
    .p2_in_i(p2_in), .p2_out_o(p2_out), .p2_oe_o(p2_oe), .p2_mux_o(p2_mux),
    .p3_io_in_i(p3_io_in), .p3_io_out_o(p3_io_out), .p3_io_oe_o(p3_io_oe),
    .p3_gpi_i(p3_gpi), .p3_gpo_o(p3_gpo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0; we = 1'b0;
    end
  endtask

  // monitor: read data is valid one cycle after the request
  always @(posedge clk) rd_pend <= rst_n && req && !we;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected read", rdata, 32'hx);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 p0_oe", 32'(p0_oe), 0);
    chk("R1 p3_io_oe", 32'(p3_io_oe), 0);
    chk("R1 p3_gpo", 32'(p3_gpo), 0);
    chk("R1 p2_mux", p2_mux, 0);
    rd(8'h0C, 0, "R1 p3 out state");
    rd(8'h18, 0, "R1 p2 dir state");
    rd(8'h30, 0, "R1 mux state");
    rd(8'h4C, 0, "R1 p0 out state");
    rd(8'h78, 0, "R1 p1 dir state");

    // port 0 set/clear
    wr(8'h44, 32'hA5);
    wr(8'h44, 32'h0F);
    idle(1);
    chk("R2 p0_out set keeps", 32'(p0_out), 32'hAF);
    wr(8'h48, 32'h81);
    idle(1);
    chk("R3 p0_out clear", 32'(p0_out), 32'h2E);
    wr(8'h44, 32'hFFFF_FF00);
    rd(8'h4C, 32'h2E, "R4 p0 bits above width ignored");
    wr(8'h50, 32'hF0);
    wr(8'h54, 32'h30);
    idle(1);
    chk("R4 p0_oe", 32'(p0_oe), 32'hC0);
    rd(8'h58, 32'hC0, "R4 p0 dir state");

    // port 1
    wr(8'h64, 32'h00AB_CDEF);
    wr(8'h68, 32'h0000_00EF);
    rd(8'h6C, 32'h00AB_CD00, "R3 p1 out state");
    wr(8'h70, 32'hFFFF_FFFF);
    idle(1);
    chk("R4 p1_oe", 32'(p1_oe), 32'h00FF_FFFF);
    rd(8'h78, 32'h00FF_FFFF, "R4 p1 dir state width");

    // port 2 and borrowed port 3 directions
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'h1000);
    idle(1);
    chk("R2 p2_out", 32'(p2_out), 32'h0FFF);
    wr(8'h10, 32'h7E00_1234);
    idle(1);
    chk("R6 p3_io_oe via p2 dir", 32'(p3_io_oe), 32'h3F);
    chk("R4 p2_oe", 32'(p2_oe), 32'h1234);
    wr(8'h14, 32'h0200_0004);
    rd(8'h18, 32'h7C00_1230, "R6 p2 dir state");
    idle(1);
    chk("R6 p3_io_oe cleared pin0", 32'(p3_io_oe), 32'h3E);
    chk("R4 p2_oe clear", 32'(p2_oe), 32'h1230);

    // mux word
    wr(8'h28, 32'hDEAD_BEEF);
    wr(8'h2C, 32'h0000_FFFF);
    rd(8'h30, 32'hDEAD_0000, "R12 mux state");
    idle(1);
    chk("R12 p2_mux_o", p2_mux, 32'hDEAD_0000);

    // port 3 outputs
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h7EFF_FFFF, "R9 p3 out state masked");
    wr(8'h08, 32'h0400_0001);
    idle(1);
    chk("R9 p3_gpo", 32'(p3_gpo), 32'h00FF_FFFE);
    chk("R6 p3_io_out", 32'(p3_io_out), 32'h3D);

    // set/clear and unmapped reads, unmapped writes
    rd(8'h04, 0, "R11 set offset reads zero");
    rd(8'h44, 0, "R11 p0 set offset reads zero");
    rd(8'h14, 0, "R11 clear offset reads zero");
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h34, 0, "R11 unmapped read");
    rd(8'h5C, 0, "R11 unmapped gap read");
    rd(8'h80, 0, "R11 unmapped high read");
    rd(8'h4C, 32'h2E, "R11 unmapped write no effect p0");
    rd(8'h30, 32'hDEAD_0000, "R11 unmapped write no effect mux");
    idle(1);
    chk("R11 p0_oe unchanged", 32'(p0_oe), 32'hC0);

    // input synchroniser latency
    @(negedge clk); req = 1'b0; p0_in = 8'h5A;
    rd(8'h40, 0, "R10 p0 input not yet visible");
    rd(8'h40, 32'h5A, "R10 p0 input after two stages");
    @(negedge clk); req = 1'b0; p1_in = 24'h12_3456; p2_in = 13'h1ABC;
    idle(2);
    rd(8'h60, 32'h0012_3456, "R10 p1 input");
    rd(8'h1C, 32'h0000_1ABC, "R10 p2 input");

    // port 3 input mapping
    @(negedge clk); req = 1'b0; p3_gpi = '1; p3_io_in = '0;
    idle(2);
    rd(8'h00, 32'h1EFF_83FF, "R8 gpi bits, 10..14 and 24 ignored");
    @(negedge clk); req = 1'b0; p3_gpi = '0; p3_io_in = 6'h3F;
    idle(2);
    rd(8'h00, 32'h0100_7C00, "R7 bidir readback bits");
    @(negedge clk); req = 1'b0; p3_io_in = 6'h20;
    idle(2);
    rd(8'h00, 32'h0100_0000, "R7 bidir pin5 at bit 24");
    @(negedge clk); req = 1'b0; p3_io_in = 6'h01;
    idle(2);
    rd(8'h00, 32'h0000_0400, "R7 bidir pin0 at bit 10");

    idle(3);
    chk("R5 all reads returned", 32'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule